// File: doc/BRIEF.md
# Memory Test Access Port with Three-Bit Instruction Decode

This block is the serial test port of a memory device. A 16-state controller runs on the rising edge of the test clock and is steered by the mode-select input. It moves a 3-bit instruction through a shift stage and a holding register. The instruction in the holding register chooses which data register sits between the serial input and the serial output. There are three data registers: a 1-bit pass-through stage, a 32-bit identification word and a boundary chain whose length is a parameter.

The boundary cells appear at the block edge as two vectors. The capture vector carries the present pin states into the chain. The update vector carries what the chain last latched back out. One instruction asks the pin drivers to apply the update vector. Another forces every memory output driver into high impedance while the pin states are still captured.

The serial output changes on the falling test-clock edge. It comes with an enable that is high only while a register is shifting. Bits move from the serial input toward the serial output, least significant bit first.

Top module: `scan_tap_port`

## Requirements
- R1: While trst_n is low, and on leaving the reset state, the instruction becomes IDCODE (3'b001). After reset, a data scan of 32 bits returns the identification word, tdo_oe is 0, and out_hiz and pin_drive are 0.
- R2: Five consecutive rising test-clock edges with tms high bring the controller to its reset state from any state. The next edge with tms low reloads IDCODE.
- R3: In the IR capture state, the value 3'b001 is loaded into the instruction shift stage. A 3-bit IR shift therefore emits 1, 0, 0 in that order.
- R4: The active instruction changes only when the controller passes through the IR update state (or the reset state). Shifting and pausing in the IR path leave out_hiz unchanged.
- R5: The identification word is {3'b000, DEV_ID[16:0], VENDOR[10:0], 1'b1}, shifted out bit 0 first. With the default parameters it is {3'b000, 17'h0B5C3, 11'h034, 1'b1}.
- R6: BYPASS (3'b111) selects a 1-bit register that captures 0. Serial input reappears at tdo after one shift.
- R7: The reserved codes 3'b011, 3'b101 and 3'b110 select the 1-bit bypass register.
- R8: SAMPLE/PRELOAD (3'b100) selects the BS_LEN-bit boundary chain. Capture loads pin_capture (bit 0 leaves first). The shifted-in data appears on pin_update after the DR update state. out_hiz and pin_drive stay 0.
- R9: SAMPLE-HIZ (3'b010) selects the boundary chain and holds out_hiz at 1 while it is the active instruction. The other instructions hold out_hiz at 0.
- R10: EXTEST (3'b000) selects the boundary chain and holds pin_drive at 1. The other instructions hold pin_drive at 0.
- R11: tdo changes only on the falling edge of tck. tdo_oe is 1 exactly in the DR and IR shift states.
- R12: pin_update changes only on a DR update while a boundary-chain instruction is active. Scans of other registers leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data input |
| pin_capture | input | BS_LEN | Pin states seen by the boundary cells |
| tdo | output | 1 | Serial data output, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| pin_update | output | BS_LEN | Boundary update register contents |
| pin_drive | output | 1 | Pins take pin_update (EXTEST active) |
| out_hiz | output | 1 | Force memory output drivers to high impedance |

## Verification
Suppose the controller state goes wrong, for example a missed transition. It shows at the ports within one test-clock period, as tdo_oe rising or falling in the wrong slot. A wrong decode of the instruction register shows in two ways. out_hiz or pin_drive change right after the IR update. The length of the serial path also changes, so a marker bit pushed in during the next DR scan comes out at the wrong position. A stale or corrupted capture shows in the first bits of the following shift, and a stray update shows on pin_update as soon as another register is scanned.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_EXTEST     = 3'b000;
  localparam logic [OP_W-1:0] OP_IDCODE     = 3'b001;
  localparam logic [OP_W-1:0] OP_SAMPLE_HIZ = 3'b010;
  localparam logic [OP_W-1:0] OP_SAMPLE     = 3'b100;
  localparam logic [OP_W-1:0] OP_BYPASS     = 3'b111;
  localparam logic [OP_W-1:0] OP_CAPTURE    = 3'b001;

  typedef enum logic [1:0] {
    DR_PASS, DR_IDENT, DR_CHAIN
  } dr_sel_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_q
);

  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  // checker: run of consecutive tms-high edges, saturating at five
  logic [2:0] tms_run_q;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)              tms_run_q <= 3'd0;
    else if (!tms)           tms_run_q <= 3'd0;
    else if (tms_run_q != 3'd5) tms_run_q <= tms_run_q + 3'd1;
  end

  p_five_ones_reset_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (tms_run_q == 3'd5) |-> (state_q == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_lsb,
  output dr_sel_e    dr_sel,
  output logic       hiz,
  output logic       drive
);

  logic [OP_W-1:0] sr_q, sr_d, op_q, op_d;
  logic            sr_en, op_en;

  always_comb begin
    sr_en = (state == ST_CAP_IR) || (state == ST_SHF_IR);
    sr_d  = (state == ST_CAP_IR) ? OP_CAPTURE : {tdi, sr_q[OP_W-1:1]};
    op_en = (state == ST_UPD_IR) || (state == ST_RESET);
    op_d  = (state == ST_RESET) ? OP_IDCODE : sr_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= OP_CAPTURE;
      op_q <= OP_IDCODE;
    end else begin
      if (sr_en) sr_q <= sr_d;
      if (op_en) op_q <= op_d;
    end
  end

  always_comb begin
    hiz   = 1'b0;
    drive = 1'b0;
    unique case (op_q)
      OP_EXTEST:     begin dr_sel = DR_CHAIN; drive = 1'b1; end
      OP_IDCODE:     dr_sel = DR_IDENT;
      OP_SAMPLE_HIZ: begin dr_sel = DR_CHAIN; hiz = 1'b1; end
      OP_SAMPLE:     dr_sel = DR_CHAIN;
      default:       dr_sel = DR_PASS;
    endcase
  end

  assign ir_lsb = sr_q[0];

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (sr_q == OP_CAPTURE));
  p_op_hold_r4: assert property (@(posedge tck) disable iff (!rst_n)
    !((state == ST_UPD_IR) || (state == ST_RESET)) |=> $stable(op_q));
  p_op_reset_r1: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |=> (op_q == OP_IDCODE));

endmodule

// File: rtl/tap_dregs.sv
module tap_dregs
  import scan_tap_pkg::*;
#(
  parameter int          BS_LEN   = 109,
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h1
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tdi,
  input  tap_state_e        state,
  input  dr_sel_e           dr_sel,
  input  logic [BS_LEN-1:0] pin_capture,
  output logic [BS_LEN-1:0] pin_update,
  output logic              dr_lsb
);

  logic              pass_q, pass_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [BS_LEN-1:0] bs_q, bs_d, upd_q;
  logic              cap_en, shf_en, pass_en, id_en, bs_en, upd_en;

  always_comb begin
    cap_en  = (state == ST_CAP_DR);
    shf_en  = (state == ST_SHF_DR);
    pass_en = cap_en || (shf_en && dr_sel == DR_PASS);
    id_en   = cap_en || (shf_en && dr_sel == DR_IDENT);
    bs_en   = cap_en || (shf_en && dr_sel == DR_CHAIN);
    upd_en  = (state == ST_UPD_DR) && (dr_sel == DR_CHAIN);
    pass_d  = cap_en ? 1'b0 : tdi;
    id_d    = cap_en ? ID_VALUE[ID_W-1:0] : {tdi, id_q[ID_W-1:1]};
    bs_d    = cap_en ? pin_capture : {tdi, bs_q[BS_LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      id_q   <= '0;
      bs_q   <= '0;
      upd_q  <= '0;
    end else begin
      if (pass_en) pass_q <= pass_d;
      if (id_en)   id_q   <= id_d;
      if (bs_en)   bs_q   <= bs_d;
      if (upd_en)  upd_q  <= bs_q;
    end
  end

  always_comb begin
    unique case (dr_sel)
      DR_IDENT: dr_lsb = id_q[0];
      DR_CHAIN: dr_lsb = bs_q[0];
      default:  dr_lsb = pass_q;
    endcase
  end

  assign pin_update = upd_q;

  p_pass_capture_r6: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR) |=> (pass_q == 1'b0));
  p_id_marker_r5: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR) |=> (id_q[0] == 1'b1));
  p_update_hold_r12: assert property (@(posedge tck) disable iff (!rst_n)
    !((state == ST_UPD_DR) && (dr_sel == DR_CHAIN)) |=> $stable(upd_q));

endmodule

// File: rtl/scan_tap_port.sv
module scan_tap_port
  import scan_tap_pkg::*;
#(
  parameter int          BS_LEN      = 109,
  parameter int          SYNC_STAGES = 2,
  parameter logic [2:0]  REVISION    = 3'b000,
  parameter logic [16:0] DEV_ID      = 17'h0B5C3,
  parameter logic [10:0] VENDOR      = 11'h034
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [BS_LEN-1:0] pin_capture,
  output logic              tdo,
  output logic              tdo_oe,
  output logic [BS_LEN-1:0] pin_update,
  output logic              pin_drive,
  output logic              out_hiz
);

  localparam logic [31:0] ID_VALUE = {REVISION, DEV_ID, VENDOR, 1'b1};
  localparam int          ID_W     = 32;

  // reset: asserted at once, released after SYNC_STAGES rising tck edges
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_n;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = sync_q[SYNC_STAGES-1];

  tap_state_e state;
  dr_sel_e    dr_sel;
  logic       ir_lsb, dr_lsb;
  logic       tdo_d, oe_d, tdo_q, oe_q;

  tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state_q(state));

  tap_ir u_ir (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state),
    .ir_lsb(ir_lsb), .dr_sel(dr_sel), .hiz(out_hiz), .drive(pin_drive)
  );

  tap_dregs #(.BS_LEN(BS_LEN), .ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state), .dr_sel(dr_sel),
    .pin_capture(pin_capture), .pin_update(pin_update), .dr_lsb(dr_lsb)
  );

  always_comb begin
    oe_d  = (state == ST_SHF_DR) || (state == ST_SHF_IR);
    tdo_d = (state == ST_SHF_IR) ? ir_lsb : dr_lsb;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= oe_d;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  p_oe_window_r11: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> ((state == ST_SHF_DR) || (state == ST_SHF_IR)));
  p_hiz_rise_r9: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(out_hiz) |-> ($past(state) == ST_UPD_IR));

endmodule

// File: tb/scan_tap_port_test.sv
`timescale 1ns/1ps
module scan_tap_port_test;

  localparam int BS  = 109;
  localparam int MAXN = 160;
  localparam logic [31:0] IDW = {3'b000, 17'h0B5C3, 11'h034, 1'b1};

  // {code[2:0], path length[7:0], out_hiz, pin_drive}
  localparam logic [12:0] VECS [8] = '{
    {3'b000, 8'd109, 1'b0, 1'b1},
    {3'b001, 8'd32,  1'b0, 1'b0},
    {3'b010, 8'd109, 1'b1, 1'b0},
    {3'b011, 8'd1,   1'b0, 1'b0},
    {3'b100, 8'd109, 1'b0, 1'b0},
    {3'b101, 8'd1,   1'b0, 1'b0},
    {3'b110, 8'd1,   1'b0, 1'b0},
    {3'b111, 8'd1,   1'b0, 1'b0}
  };

  logic          tck, trst_n, tms, tdi;
  logic [BS-1:0] pin_capture, pin_update;
  logic          tdo, tdo_oe, pin_drive, out_hiz;

  int total = 0, bad = 0, timing_bad = 0, oe_bad = 0;
  logic last_tdo, last_oe;

  scan_tap_port uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_capture(pin_capture),
    .tdo(tdo), .tdo_oe(tdo_oe), .pin_update(pin_update),
    .pin_drive(pin_drive), .out_hiz(out_hiz)
  );

  initial tck = 1'b0;
  always #2 tck = ~tck;

  task automatic check(input string req, input logic [MAXN-1:0] act, input logic [MAXN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one tck period: inputs set and outputs sampled mid-low, tdo re-checked after the rise
  task automatic tick(input logic m, input logic d, input logic oe_exp);
    tms = m; tdi = d;
    last_tdo = tdo; last_oe = tdo_oe;
    if (last_oe !== oe_exp) oe_bad++;
    @(posedge tck); #1;
    if (tdo !== last_tdo) timing_bad++;
    @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    tick(1, 0, 0); tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i], 1);
      cap[i] = last_tdo;
    end
    tick(1, 0, 0); tick(0, 0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [MAXN-1:0] din, output logic [MAXN-1:0] dout);
    dout = '0;
    tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], 1);
      dout[i] = last_tdo;
    end
    tick(1, 0, 0); tick(0, 0, 0);
  endtask

  logic finished = 1'b0;

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0]      cap;
    logic [MAXN-1:0] dout, din, expv;
    logic [BS-1:0]   pins, pre;

    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; pin_capture = '0;
    @(negedge tck); #1;
    repeat (3) begin @(negedge tck); #1; end
    // R1 reset state at the ports
    check("R1 tdo_oe", MAXN'(tdo_oe), MAXN'(0));
    check("R1 out_hiz", MAXN'(out_hiz), MAXN'(0));
    check("R1 pin_drive", MAXN'(pin_drive), MAXN'(0));
    check("R12 pin_update reset", MAXN'(pin_update), MAXN'(0));
    trst_n = 1'b1;
    repeat (5) tick(1, 0, 0);
    tick(0, 0, 0);
    scan_dr(32, '0, dout);
    check("R1 R5 default IDCODE word", MAXN'(dout[31:0]), MAXN'(IDW));

    // table walk: R3 IR capture, R6 R7 R8 R9 R10 path select and flags
    for (int k = 0; k < 8; k++) begin
      logic [12:0] v;
      int len;
      v = VECS[k];
      len = int'(v[9:2]);
      load_ir(v[12:10], cap);
      check($sformatf("R3 capture code=%b", v[12:10]), MAXN'(cap), MAXN'(3'b001));
      check($sformatf("R9 out_hiz code=%b", v[12:10]), MAXN'(out_hiz), MAXN'(v[1]));
      check($sformatf("R10 pin_drive code=%b", v[12:10]), MAXN'(pin_drive), MAXN'(v[0]));
      expv = '0;
      if (len == 32) expv[31:0] = IDW;
      expv[len] = 1'b1;
      din = '0; din[0] = 1'b1;
      scan_dr(112, din, dout);
      check($sformatf("R6 R7 R8 path length code=%b", v[12:10]),
            MAXN'(dout[111:0]), MAXN'(expv[111:0]));
    end

    // R8 SAMPLE/PRELOAD with a pin pattern
    pins = BS'({4{32'hA5C3_96E1}});
    pin_capture = pins;
    load_ir(3'b100, cap);
    check("R8 out_hiz low", MAXN'(out_hiz), MAXN'(0));
    din = MAXN'({5{32'h3C0F_F0C3}});
    scan_dr(BS, din, dout);
    check("R8 captured pins", MAXN'(dout[BS-1:0]), MAXN'(pins));
    check("R8 preload update", MAXN'(pin_update), MAXN'(din[BS-1:0]));
    pre = pin_update;

    // R12 scans of other registers leave pin_update alone
    load_ir(3'b001, cap);
    scan_dr(32, MAXN'(32'hFFFF_0000), dout);
    check("R12 hold after ID scan", MAXN'(pin_update), MAXN'(pre));
    load_ir(3'b111, cap);
    scan_dr(5, MAXN'(5'b10110), dout);
    check("R6 bypass one-bit delay", MAXN'(dout[4:1]), MAXN'(4'b0110));
    check("R12 hold after bypass scan", MAXN'(pin_update), MAXN'(pre));

    // R4 instruction takes effect only at IR update
    load_ir(3'b001, cap);
    tick(1, 0, 0); tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    tick(0, 0, 1); tick(0, 1, 1); tick(1, 0, 1);
    tick(0, 0, 0);
    check("R4 pause keeps op", MAXN'(out_hiz), MAXN'(0));
    tick(1, 0, 0); tick(1, 0, 0);
    check("R4 update state not yet applied", MAXN'(out_hiz), MAXN'(0));
    tick(0, 0, 0);
    check("R4 applied after update", MAXN'(out_hiz), MAXN'(1));

    // R2 five tms-high edges from Shift-DR reach reset
    tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    tick(1, 0, 1); tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0);
    tick(0, 0, 0);
    check("R2 hiz cleared by reset", MAXN'(out_hiz), MAXN'(0));
    scan_dr(32, '0, dout);
    check("R2 IDCODE after reset", MAXN'(dout[31:0]), MAXN'(IDW));

    // R11 enable window and falling-edge output timing across all ticks
    check("R11 tdo_oe window", MAXN'(oe_bad), MAXN'(0));
    check("R11 tdo stable at rising edge", MAXN'(timing_bad), MAXN'(0));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule